// File: doc/BRIEF.md
# Miss-Merging Line Fill Tracker

This block sits between a direct-mapped, write-through data cache that does not allocate on writes and the memory scheduler, and keeps track of cache lines whose fill is still outstanding. Each tracking entry holds one line address, four waiting-load slots (a valid bit, a processor tag and a word offset each), a busy flag and an issued flag. The first load miss to an untracked line claims the lowest free entry and asks the scheduler for the whole line. The scheduler's request tag is the entry number. Later load misses to the same line only occupy a free slot of that entry and never cause a second read.

When the scheduler returns a line, its tag names the entry. In the next cycle the line is offered to the cache array for writing, and the block starts replaying the waiting loads, one per cycle. Each load gets the word it asked for, labelled with its processor tag. When the last waiting slot has been answered, the entry becomes free. A store to a line that is being tracked is held off until the entry retires. A load miss is held off when it cannot be recorded.

Top module: `miss_merge_buf`

## Requirements
- R1: A load miss (`ld_valid` high) to a line that no busy entry holds is accepted in the same cycle (`ld_stall` low) whenever some entry is free. It claims the lowest-numbered free entry. That entry then raises a read request with `rd_req_id` equal to the entry number and `rd_req_line` equal to `ld_addr[ADDR_W-1:2]`.
- R2: Each entry makes exactly one read request per allocation. The request stays up until `rd_req_ready` is seen high on a clock edge. When several entries are waiting, the lowest-numbered one is presented first.
- R3: A load miss to a line that a busy entry already holds is accepted into a free slot of that entry, and no further read request appears.
- R4: A load miss is stalled when its line's entry has all four slots in use. It is also stalled when its line is untracked and every entry is busy. A miss that merges into an existing entry is still accepted when all entries are busy.
- R5: `fill_valid` with `fill_ready` high is accepted on the clock edge. From the next cycle on, `resp_valid` is high for one cycle per waiting load, in the order the loads were accepted. Each response carries that load's `ld_ptag` and word `ld_addr[1:0]` of the line, where word w is `fill_data[w*DATA_W +: DATA_W]`.
- R6: `cwr_valid` is high for exactly one cycle, the cycle of the first response, with `cwr_line` holding the entry's line and `cwr_data` holding the returned line.
- R7: `fill_ready` is low while a replay is in progress. After the last response the entry is free: stores to its line no longer stall, and a new load to that line allocates again and issues a new read.
- R8: `st_stall` is high in the same cycle exactly when `st_valid` is high and `st_addr[ADDR_W-1:2]` equals the line of an entry that is busy (from allocation to the end of its replay).
- R9: A load miss to the line whose entry is currently replaying is stalled.
- R10: During reset and right after it, `rd_req_valid`, `resp_valid`, `cwr_valid`, `ld_stall` and `st_stall` are low and `fill_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load miss presented |
| ld_addr | input | ADDR_W | Word address of the load miss |
| ld_ptag | input | PTAG_W | Processor tag of the load |
| ld_stall | output | 1 | Load miss not accepted this cycle |
| st_valid | input | 1 | Store presented |
| st_addr | input | ADDR_W | Word address of the store |
| st_stall | output | 1 | Store must wait |
| rd_req_valid | output | 1 | Line read request to the scheduler |
| rd_req_ready | input | 1 | Scheduler takes the request |
| rd_req_line | output | ADDR_W-2 | Line address of the request |
| rd_req_id | output | log2(NUM_ENT) | Entry number used as request tag |
| fill_valid | input | 1 | Returned line presented |
| fill_ready | output | 1 | Returned line can be accepted |
| fill_id | input | log2(NUM_ENT) | Tag of the returned line |
| fill_data | input | 4*DATA_W | Returned line, word 0 in the low bits |
| cwr_valid | output | 1 | Write the returned line into the cache array |
| cwr_line | output | ADDR_W-2 | Line address of the cache write |
| cwr_data | output | 4*DATA_W | Line data of the cache write |
| resp_valid | output | 1 | Replayed load response |
| resp_ptag | output | PTAG_W | Processor tag of the response |
| resp_data | output | DATA_W | Requested word |

## Verification
On every cycle, the assertions check several structural rules. At most one busy entry matches a line. Only free entries are allocated, and only non-full busy entries take merges. No entry issues twice. An entry frees itself only through a replay pop. The cache write lasts one cycle. A replaying entry always has a waiting slot, and stores never stall while nothing is tracked. Only the directed scenarios can show the data-level results: which entry number a request carries, the slot order and the word chosen for each response, which stall cases are reached when slots or entries run out, and that an entry is reused after it retires.

// File: rtl/mmb_pkg.sv
package mmb_pkg;

   // replay sequencer state
   typedef enum logic [1:0] {
      RP_IDLE  = 2'd0,
      RP_FIRST = 2'd1,
      RP_DRAIN = 2'd2
   } rp_state_e;

   // index width for a count of items, never below one bit
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mmb_pick.sv
module mmb_pick #(
   parameter int unsigned N = 4,
   localparam int unsigned W = mmb_pkg::idx_width(N)
) (
   input  logic [N-1:0] req_i,
   output logic         found_o,
   output logic [W-1:0] idx_o
);

   generate
      if (N == 1) begin : g_single
         assign found_o = req_i[0];
         assign idx_o   = '0;
      end else begin : g_multi
         always_comb begin
            found_o = |req_i;
            idx_o   = '0;
            for (int k = N - 1; k >= 0; k--) begin
               if (req_i[k]) idx_o = W'(k);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mmb_entry.sv
module mmb_entry #(
   parameter int unsigned LINE_W = 10,
   parameter int unsigned PTAG_W = 4,
   parameter int unsigned SLOTS  = 4,
   parameter int unsigned OFF_W  = 2,
   localparam int unsigned SL_W  = mmb_pkg::idx_width(SLOTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc_i,
   input  logic                    merge_i,
   input  logic [LINE_W-1:0]       line_i,
   input  logic [PTAG_W-1:0]       ptag_i,
   input  logic [OFF_W-1:0]        woff_i,
   input  logic                    issue_i,
   input  logic                    pop_i,
   input  logic [SL_W-1:0]         pop_slot_i,
   output logic                    busy_o,
   output logic                    issued_o,
   output logic                    full_o,
   output logic [LINE_W-1:0]       line_o,
   output logic [SLOTS-1:0]        vld_o,
   output logic [SLOTS*PTAG_W-1:0] ptag_o,
   output logic [SLOTS*OFF_W-1:0]  woff_o
);

   logic                busy_q, issued_q;
   logic [LINE_W-1:0]   line_q;
   logic [SLOTS-1:0]    vld_q, vld_nxt, vld_left;
   logic [PTAG_W-1:0]   ptag_q [SLOTS];
   logic [OFF_W-1:0]    woff_q [SLOTS];
   logic                free_found;
   logic [SL_W-1:0]     free_slot, wr_slot;
   logic [SLOTS-1:0]    pop_mask;

   mmb_pick #(.N(SLOTS)) u_free_slot (
      .req_i   (~vld_q),
      .found_o (free_found),
      .idx_o   (free_slot)
   );

   assign full_o   = ~free_found;
   assign wr_slot  = alloc_i ? '0 : free_slot;
   assign pop_mask = SLOTS'(1) << pop_slot_i;
   assign vld_left = vld_q & ~pop_mask;

   always_comb begin
      vld_nxt = vld_q;
      if (alloc_i)
         vld_nxt = SLOTS'(1);
      else if (merge_i)
         vld_nxt = vld_q | (SLOTS'(1) << free_slot);
      else if (pop_i)
         vld_nxt = vld_left;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         issued_q <= 1'b0;
         line_q   <= '0;
         vld_q    <= '0;
         for (int s = 0; s < SLOTS; s++) begin
            ptag_q[s] <= '0;
            woff_q[s] <= '0;
         end
      end else begin
         vld_q <= vld_nxt;
         if (issue_i) issued_q <= 1'b1;
         if (alloc_i) begin
            busy_q   <= 1'b1;
            issued_q <= 1'b0;
            line_q   <= line_i;
         end
         if (alloc_i || merge_i) begin
            ptag_q[wr_slot] <= ptag_i;
            woff_q[wr_slot] <= woff_i;
         end
         if (pop_i && !alloc_i && vld_left == '0) busy_q <= 1'b0;
      end
   end

   assign busy_o   = busy_q;
   assign issued_o = issued_q;
   assign line_o   = line_q;
   assign vld_o    = vld_q;

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_flat
         assign ptag_o[s*PTAG_W +: PTAG_W] = ptag_q[s];
         assign woff_o[s*OFF_W +: OFF_W]   = woff_q[s];
      end
   endgenerate

   // only a free entry may be claimed
   assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> !busy_q);

   // a read leaves an entry at most once per allocation
   assert_one_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |-> (busy_q && !issued_q));

   // merging needs a busy entry with room
   assert_merge_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
      merge_i |-> (busy_q && free_found));

   // an entry retires only through a replay pop
   assert_free_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(pop_i));

endmodule

// File: rtl/mmb_replay.sv
module mmb_replay
   import mmb_pkg::*;
#(
   parameter int unsigned NUM_ENT    = 4,
   parameter int unsigned SLOTS      = 4,
   parameter int unsigned PTAG_W     = 4,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned LINE_WORDS = 4,
   localparam int unsigned IDX_W     = idx_width(NUM_ENT),
   localparam int unsigned SL_W      = idx_width(SLOTS),
   localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
   localparam int unsigned LDATA_W   = LINE_WORDS * DATA_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fill_valid_i,
   input  logic [IDX_W-1:0]        fill_id_i,
   input  logic [LDATA_W-1:0]      fill_data_i,
   input  logic [SLOTS-1:0]        sel_vld_i,
   input  logic [SLOTS*PTAG_W-1:0] sel_ptag_i,
   input  logic [SLOTS*OFF_W-1:0]  sel_woff_i,
   output logic                    fill_ready_o,
   output logic                    busy_o,
   output logic                    first_o,
   output logic [IDX_W-1:0]        idx_o,
   output logic [LDATA_W-1:0]      data_o,
   output logic                    pop_o,
   output logic [SL_W-1:0]         pop_slot_o,
   output logic                    resp_valid_o,
   output logic [PTAG_W-1:0]       resp_ptag_o,
   output logic [DATA_W-1:0]       resp_data_o
);

   rp_state_e          state_q;
   logic [IDX_W-1:0]   idx_q;
   logic [LDATA_W-1:0] data_q;
   logic               slot_found, last_slot;
   logic [SL_W-1:0]    slot;
   logic [OFF_W-1:0]   woff;

   mmb_pick #(.N(SLOTS)) u_slot_pick (
      .req_i   (sel_vld_i),
      .found_o (slot_found),
      .idx_o   (slot)
   );

   assign fill_ready_o = (state_q == RP_IDLE);
   assign busy_o       = (state_q != RP_IDLE);
   assign first_o      = (state_q == RP_FIRST);
   assign idx_o        = idx_q;
   assign data_o       = data_q;
   assign pop_o        = busy_o && slot_found;
   assign pop_slot_o   = slot;
   assign last_slot    = ($countones(sel_vld_i) == 1);
   assign woff         = sel_woff_i[slot*OFF_W +: OFF_W];

   assign resp_valid_o = pop_o;
   assign resp_ptag_o  = sel_ptag_i[slot*PTAG_W +: PTAG_W];
   assign resp_data_o  = data_q[woff*DATA_W +: DATA_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RP_IDLE;
         idx_q   <= '0;
         data_q  <= '0;
      end else begin
         unique case (state_q)
            RP_IDLE: begin
               if (fill_valid_i) begin
                  state_q <= RP_FIRST;
                  idx_q   <= fill_id_i;
                  data_q  <= fill_data_i;
               end
            end
            RP_FIRST, RP_DRAIN: begin
               if (!slot_found || last_slot) state_q <= RP_IDLE;
               else                         state_q <= RP_DRAIN;
            end
            default: state_q <= RP_IDLE;
         endcase
      end
   end

   // the cache array is written in one cycle only
   assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      first_o |=> !first_o);

   // a replaying entry always has a waiting load
   assert_resp_has_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (|sel_vld_i));

endmodule

// File: rtl/miss_merge_buf.sv
module miss_merge_buf
   import mmb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned PTAG_W     = 4,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_ENT    = 4,
   parameter int unsigned SLOTS      = 4,
   parameter int unsigned LINE_WORDS = 4,
   localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
   localparam int unsigned LINE_W    = ADDR_W - OFF_W,
   localparam int unsigned IDX_W     = idx_width(NUM_ENT),
   localparam int unsigned SL_W      = idx_width(SLOTS),
   localparam int unsigned LDATA_W   = LINE_WORDS * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_valid,
   input  logic [ADDR_W-1:0]  ld_addr,
   input  logic [PTAG_W-1:0]  ld_ptag,
   output logic               ld_stall,
   input  logic               st_valid,
   input  logic [ADDR_W-1:0]  st_addr,
   output logic               st_stall,
   output logic               rd_req_valid,
   input  logic               rd_req_ready,
   output logic [LINE_W-1:0]  rd_req_line,
   output logic [IDX_W-1:0]   rd_req_id,
   input  logic               fill_valid,
   output logic               fill_ready,
   input  logic [IDX_W-1:0]   fill_id,
   input  logic [LDATA_W-1:0] fill_data,
   output logic               cwr_valid,
   output logic [LINE_W-1:0]  cwr_line,
   output logic [LDATA_W-1:0] cwr_data,
   output logic               resp_valid,
   output logic [PTAG_W-1:0]  resp_ptag,
   output logic [DATA_W-1:0]  resp_data
);

   generate
      if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_words
         $error("line word count must be a power of two of at least 2");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("address must be wider than the word offset");
      end
      if (NUM_ENT < 1 || SLOTS < 1) begin : g_bad_count
         $error("entry and slot counts must be positive");
      end
   endgenerate

   logic [LINE_W-1:0]       ld_line, st_line;
   logic [OFF_W-1:0]        ld_woff;
   logic [NUM_ENT-1:0]      ent_busy, ent_issued, ent_full;
   logic [NUM_ENT-1:0]      ld_match, st_match, rd_pend;
   logic [NUM_ENT-1:0]      alloc_v, merge_v, issue_v, pop_v;
   logic [LINE_W-1:0]       ent_line [NUM_ENT];
   logic [SLOTS-1:0]        ent_vld  [NUM_ENT];
   logic [SLOTS*PTAG_W-1:0] ent_ptag [NUM_ENT];
   logic [SLOTS*OFF_W-1:0]  ent_woff [NUM_ENT];

   logic                    ld_hit, ld_acc, any_free, match_full, match_replay;
   logic [IDX_W-1:0]        free_idx, unused_hit_idx;

   logic                    rp_busy, rp_first, rp_pop;
   logic [IDX_W-1:0]        rp_idx;
   logic [SL_W-1:0]         rp_slot;
   logic [LDATA_W-1:0]      rp_data;

   assign ld_line = ld_addr[ADDR_W-1:OFF_W];
   assign ld_woff = ld_addr[OFF_W-1:0];
   assign st_line = st_addr[ADDR_W-1:OFF_W];

   // free entry and pending request selection
   mmb_pick #(.N(NUM_ENT)) u_free_pick (
      .req_i   (~ent_busy),
      .found_o (any_free),
      .idx_o   (free_idx)
   );

   mmb_pick #(.N(NUM_ENT)) u_req_pick (
      .req_i   (rd_pend),
      .found_o (rd_req_valid),
      .idx_o   (rd_req_id)
   );

   mmb_pick #(.N(NUM_ENT)) u_hit_pick (
      .req_i   (ld_match),
      .found_o (ld_hit),
      .idx_o   (unused_hit_idx)
   );

   assign match_full   = |(ld_match & ent_full);
   assign match_replay = rp_busy && ld_match[rp_idx];
   assign ld_stall     = ld_valid && (ld_hit ? (match_full || match_replay) : !any_free);
   assign ld_acc       = ld_valid && !ld_stall;
   assign st_stall     = st_valid && (|st_match);
   assign rd_req_line  = ent_line[rd_req_id];

   generate
      for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
         assign ld_match[e] = ent_busy[e] && (ent_line[e] == ld_line);
         assign st_match[e] = ent_busy[e] && (ent_line[e] == st_line);
         assign rd_pend[e]  = ent_busy[e] && !ent_issued[e];
         assign alloc_v[e]  = ld_acc && !ld_hit && (free_idx == IDX_W'(e));
         assign merge_v[e]  = ld_acc && ld_match[e];
         assign issue_v[e]  = rd_req_valid && rd_req_ready && (rd_req_id == IDX_W'(e));
         assign pop_v[e]    = rp_pop && (rp_idx == IDX_W'(e));

         mmb_entry #(
            .LINE_W (LINE_W),
            .PTAG_W (PTAG_W),
            .SLOTS  (SLOTS),
            .OFF_W  (OFF_W)
         ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc_v[e]),
            .merge_i    (merge_v[e]),
            .line_i     (ld_line),
            .ptag_i     (ld_ptag),
            .woff_i     (ld_woff),
            .issue_i    (issue_v[e]),
            .pop_i      (pop_v[e]),
            .pop_slot_i (rp_slot),
            .busy_o     (ent_busy[e]),
            .issued_o   (ent_issued[e]),
            .full_o     (ent_full[e]),
            .line_o     (ent_line[e]),
            .vld_o      (ent_vld[e]),
            .ptag_o     (ent_ptag[e]),
            .woff_o     (ent_woff[e])
         );
      end
   endgenerate

   mmb_replay #(
      .NUM_ENT    (NUM_ENT),
      .SLOTS      (SLOTS),
      .PTAG_W     (PTAG_W),
      .DATA_W     (DATA_W),
      .LINE_WORDS (LINE_WORDS)
   ) u_replay (
      .clk          (clk),
      .rst_n        (rst_n),
      .fill_valid_i (fill_valid),
      .fill_id_i    (fill_id),
      .fill_data_i  (fill_data),
      .sel_vld_i    (ent_vld[rp_idx]),
      .sel_ptag_i   (ent_ptag[rp_idx]),
      .sel_woff_i   (ent_woff[rp_idx]),
      .fill_ready_o (fill_ready),
      .busy_o       (rp_busy),
      .first_o      (rp_first),
      .idx_o        (rp_idx),
      .data_o       (rp_data),
      .pop_o        (rp_pop),
      .pop_slot_o   (rp_slot),
      .resp_valid_o (resp_valid),
      .resp_ptag_o  (resp_ptag),
      .resp_data_o  (resp_data)
   );

   assign cwr_valid = rp_first;
   assign cwr_line  = ent_line[rp_idx];
   assign cwr_data  = rp_data;

   // one line never lives in two entries
   assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_match));

   // with nothing tracked, stores always proceed
   assert_store_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_busy == '0) |-> !st_stall);

endmodule

// File: tb/miss_merge_buf_tb.sv
module miss_merge_buf_tb;

   localparam int ADDR_W = 12;
   localparam int PTAG_W = 4;
   localparam int DATA_W = 16;
   localparam int NUM_ENT = 4;
   localparam int LINE_W = ADDR_W - 2;
   localparam int IDX_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ld_valid = 1'b0;
   logic [ADDR_W-1:0] ld_addr = '0;
   logic [PTAG_W-1:0] ld_ptag = '0;
   logic              ld_stall;
   logic              st_valid = 1'b0;
   logic [ADDR_W-1:0] st_addr = '0;
   logic              st_stall;
   logic              rd_req_valid;
   logic              rd_req_ready = 1'b0;
   logic [LINE_W-1:0] rd_req_line;
   logic [IDX_W-1:0]  rd_req_id;
   logic              fill_valid = 1'b0;
   logic              fill_ready;
   logic [IDX_W-1:0]  fill_id = '0;
   logic [4*DATA_W-1:0] fill_data = '0;
   logic              cwr_valid;
   logic [LINE_W-1:0] cwr_line;
   logic [4*DATA_W-1:0] cwr_data;
   logic              resp_valid;
   logic [PTAG_W-1:0] resp_ptag;
   logic [DATA_W-1:0] resp_data;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   miss_merge_buf #(
      .ADDR_W(ADDR_W), .PTAG_W(PTAG_W), .DATA_W(DATA_W), .NUM_ENT(NUM_ENT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ptag(ld_ptag), .ld_stall(ld_stall),
      .st_valid(st_valid), .st_addr(st_addr), .st_stall(st_stall),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_req_line(rd_req_line), .rd_req_id(rd_req_id),
      .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_id(fill_id), .fill_data(fill_data),
      .cwr_valid(cwr_valid), .cwr_line(cwr_line), .cwr_data(cwr_data),
      .resp_valid(resp_valid), .resp_ptag(resp_ptag), .resp_data(resp_data)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   function automatic logic [4*DATA_W-1:0] mk_line(input int id);
      logic [4*DATA_W-1:0] d;
      for (int w = 0; w < 4; w++) d[w*DATA_W +: DATA_W] = DATA_W'(16'hA000 + id * 16 + w);
      return d;
   endfunction

   function automatic logic [DATA_W-1:0] word_of(input int id, input int w);
      return DATA_W'(16'hA000 + id * 16 + w);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      ld_valid = 0; st_valid = 0; rd_req_ready = 0; fill_valid = 0;
      repeat (3) @(negedge clk);
      #1;
      chk("R10 rd_req_valid", rd_req_valid, 0);
      chk("R10 resp_valid", resp_valid, 0);
      chk("R10 cwr_valid", cwr_valid, 0);
      chk("R10 fill_ready", fill_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R10 rd_req_valid after reset", rd_req_valid, 0);
      chk("R10 ld_stall after reset", ld_stall, 0);
      chk("R10 st_stall after reset", st_stall, 0);
   endtask

   task automatic ld_try(input logic [ADDR_W-1:0] a, input logic [PTAG_W-1:0] p,
                         input logic exp_stall, input string req);
      @(negedge clk);
      ld_valid = 1; ld_addr = a; ld_ptag = p;
      #1 chk(req, ld_stall, exp_stall);
      @(negedge clk);
      ld_valid = 0;
   endtask

   task automatic st_try(input logic [ADDR_W-1:0] a, input logic exp_stall, input string req);
      @(negedge clk);
      st_valid = 1; st_addr = a;
      #1 chk(req, st_stall, exp_stall);
      st_valid = 0;
   endtask

   task automatic take_req(input int exp_id, input logic [LINE_W-1:0] exp_line, input string req);
      @(negedge clk);
      #1;
      chk({req, " request valid"}, rd_req_valid, 1);
      chk({req, " request id"}, rd_req_id, exp_id);
      chk({req, " request line"}, rd_req_line, exp_line);
      rd_req_ready = 1;
      @(negedge clk);
      rd_req_ready = 0;
   endtask

   // returns a line and checks the replayed responses in order
   task automatic fill_chk(input int id, input logic [LINE_W-1:0] line, input int n,
                           input logic [3:0][PTAG_W-1:0] ptags, input logic [3:0][1:0] woffs);
      @(negedge clk);
      fill_valid = 1; fill_id = IDX_W'(id); fill_data = mk_line(id);
      #1 chk("R5 fill_ready before fill", fill_ready, 1);
      @(negedge clk);
      fill_valid = 0;
      #1;
      for (int k = 0; k < n; k++) begin
         chk("R5 resp_valid", resp_valid, 1);
         chk("R5 resp_ptag", resp_ptag, ptags[k]);
         chk("R5 resp_data", resp_data, word_of(id, int'(woffs[k])));
         chk("R6 cwr_valid", cwr_valid, (k == 0));
         if (k == 0) begin
            chk("R6 cwr_line", cwr_line, line);
            chk("R6 cwr_data", cwr_data, mk_line(id));
         end else begin
            chk("R7 fill_ready low in replay", fill_ready, 0);
         end
         @(negedge clk);
         #1;
      end
      chk("R5 no extra response", resp_valid, 0);
      chk("R7 fill_ready after replay", fill_ready, 1);
   endtask

   task automatic t_alloc_merge();
      do_reset();
      ld_try(12'h100, 4'd1, 0, "R1 first miss");
      ld_try(12'h102, 4'd2, 0, "R3 merge before issue");
      ld_try(12'h101, 4'd3, 0, "R3 second merge");
      take_req(0, 10'h040, "R1");
      @(negedge clk);
      #1 chk("R2 R3 no second read", rd_req_valid, 0);
      st_try(12'h103, 1, "R8 store to tracked line");
      st_try(12'h203, 0, "R8 store elsewhere");
      fill_chk(0, 10'h040, 3, {4'd0, 4'd3, 4'd2, 4'd1}, {2'd0, 2'd1, 2'd2, 2'd0});
      st_try(12'h103, 0, "R7 store after retire");
      ld_try(12'h100, 4'd9, 0, "R7 realloc");
      take_req(0, 10'h040, "R7 new read");
   endtask

   task automatic t_full_slots();
      do_reset();
      for (int k = 0; k < 4; k++)
         ld_try(ADDR_W'(12'h300 + k), PTAG_W'(k + 1), 0, "R3 fill slots");
      ld_try(12'h300, 4'd5, 1, "R4 slots full");
      take_req(0, 10'h0C0, "R4");
      fill_chk(0, 10'h0C0, 4, {4'd4, 4'd3, 4'd2, 4'd1}, {2'd3, 2'd2, 2'd1, 2'd0});
   endtask

   task automatic t_entries_full();
      do_reset();
      ld_try(12'h040, 4'd1, 0, "R1 entry0");
      ld_try(12'h080, 4'd2, 0, "R1 entry1");
      ld_try(12'h0C0, 4'd3, 0, "R1 entry2");
      ld_try(12'h100, 4'd4, 0, "R1 entry3");
      ld_try(12'h140, 4'd5, 1, "R4 all entries busy");
      ld_try(12'h081, 4'd6, 0, "R4 merge while all busy");
      take_req(0, 10'h010, "R2 order0");
      take_req(1, 10'h020, "R2 order1");
      take_req(2, 10'h030, "R2 order2");
      take_req(3, 10'h040, "R2 order3");
      @(negedge clk);
      #1 chk("R2 all issued", rd_req_valid, 0);
      fill_chk(1, 10'h020, 2, {4'd0, 4'd0, 4'd6, 4'd2}, {2'd0, 2'd0, 2'd1, 2'd0});
      ld_try(12'h140, 4'd5, 0, "R7 freed entry reused");
      take_req(1, 10'h050, "R1 lowest free");
   endtask

   task automatic t_replay_block();
      do_reset();
      ld_try(12'h300, 4'd1, 0, "R1 line");
      ld_try(12'h301, 4'd2, 0, "R3 merge");
      take_req(0, 10'h0C0, "R9");
      @(negedge clk);
      fill_valid = 1; fill_id = 0; fill_data = mk_line(0);
      @(negedge clk);
      fill_valid = 0;
      ld_valid = 1; ld_addr = 12'h302; ld_ptag = 4'd7;
      st_valid = 1; st_addr = 12'h303;
      #1;
      chk("R5 first resp ptag", resp_ptag, 1);
      chk("R7 fill_ready in replay", fill_ready, 0);
      chk("R9 load to replaying line", ld_stall, 1);
      chk("R8 store during replay", st_stall, 1);
      @(negedge clk);
      ld_valid = 0; st_valid = 0;
      #1;
      chk("R5 second resp valid", resp_valid, 1);
      chk("R5 second resp ptag", resp_ptag, 2);
      chk("R5 second resp data", resp_data, word_of(0, 1));
      @(negedge clk);
      #1;
      chk("R9 stalled load not replayed", resp_valid, 0);
      chk("R7 fill_ready back", fill_ready, 1);
      chk("R9 no read from stalled load", rd_req_valid, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      t_alloc_merge();
      t_full_slots();
      t_entries_full();
      t_replay_block();
      summary();
      $finish;
   end

endmodule